// File: doc/BRIEF.md
# Static Wear-Leveling Trigger Unit

This unit sits beside a flash garbage collector and decides when cold data has to be moved so that erase wear spreads across the whole device. Each physical block belongs to a block set of 2^SET_SHIFT consecutive blocks. The unit keeps one recency flag per set, a running count of all erases since the last wipe (the erase count) and a count of raised flags (the flag count). When the erase count reaches the programmable ratio `thresh` times the flag count, erases have piled up on too few sets. The unit then searches for a set whose flag is still clear and hands that set to the collector as a cleaning request.

Erase notifications arrive on a valid/ready stream. The unit stalls that stream, by dropping `erase_ready`, for the single cycle in which it wipes the table once every flag is set. Cleaning requests leave on a second valid/ready stream. Once `clean_valid` is high, it and `clean_set` hold until `clean_ready` is seen. Only one request is outstanding at a time. The collector's `gc_done` pulse closes the request, and the unit answers with a one-cycle `remap_req` that tells the allocator to rewrite the address map for that set. The collector itself and the map update are outside the unit.

The search runs one set per cycle from a scan pointer. After a wipe the pointer restarts at a pseudo-random set, taken from a 16-bit LFSR that is also stirred by the erased block indices.

Top module: `wear_level_trigger`

## Requirements
- R1: After reset `clean_valid` and `remap_req` are 0, `erase_ready` is 1, the erase count and flag count are 0, all flags are clear and the scan pointer is set 0.
- R2: While the flag count is 0 no cleaning request is raised, whatever the value of `thresh` (including 0).
- R3: A search starts only when the erase count is at least `thresh` times the flag count, with equality counting as a trigger; below that, no request is raised.
- R4: The search takes the first set with a clear flag at or after the scan pointer, wrapping from the highest set to set 0. The pointer then rests one past the chosen set.
- R5: While `clean_valid` is 1 and `clean_ready` is 0, `clean_valid` stays 1 and `clean_set` does not change.
- R6: After a request is accepted, no new request is raised until `gc_done`. The cycle after `gc_done`, `remap_req` is 1 for exactly one cycle with `remap_set` equal to the accepted set.
- R7: An accepted erase always adds 1 to the erase count. It raises the flag count only when its set's flag was clear, so repeat erases of a set leave the flag count unchanged.
- R8: An erase of block index b marks set b >> SET_SHIFT (the upper BLK_W-SET_SHIFT bits of `erase_blk`).
- R9: When all flags are set, `erase_ready` is 0 for exactly one cycle. In that cycle the table is wiped, both counts return to 0, and the scan pointer is loaded from the LFSR.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| thresh | input | THR_W | Erase-to-flag ratio that triggers leveling |
| erase_valid | input | 1 | An erase notification is offered |
| erase_ready | output | 1 | Notification accepted this cycle (low during the wipe cycle) |
| erase_blk | input | BLK_W | Physical block index that was erased |
| clean_valid | output | 1 | A cleaning request is offered |
| clean_ready | input | 1 | Collector takes the request |
| clean_set | output | BLK_W-SET_SHIFT | Block set to move out and erase |
| gc_done | input | 1 | Collector has erased the accepted set |
| remap_req | output | 1 | One-cycle pulse asking the allocator to update the address map |
| remap_set | output | BLK_W-SET_SHIFT | Set whose mapping must be updated |

## Verification
The hardest situation to pin down from the ports is the selection after a table wipe, because the scan then starts at a pseudo-random set that the stimulus cannot predict. The stimulus fills every set to force a wipe, with a high `thresh` so nothing fires. It then re-marks all sets but one and lowers `thresh`. The chosen set is then the same wherever the scan starts. The same sequence shows that the erase count was cleared: a ratio that the stale count would have met must not fire. Before the wipe, the ratio is walked to exactly the equality point with repeat erases of one set. This separates correct flag counting from counting every erase.

// File: rtl/wl_pkg.sv
package wl_pkg;

  typedef enum logic [1:0] {
    WL_IDLE = 2'd0,
    WL_SCAN = 2'd1,
    WL_REQ  = 2'd2,
    WL_WAIT = 2'd3
  } wl_state_e;

  localparam int LFSR_W = 16;

  function automatic logic [LFSR_W-1:0] lfsr_step(input logic [LFSR_W-1:0] s);
    logic fb;
    fb = s[15] ^ s[13] ^ s[12] ^ s[10];
    return {s[14:0], fb};
  endfunction

endpackage

// File: rtl/wl_erase_table.sv
module wl_erase_table #(
  parameter int BLK_W     = 10,
  parameter int SET_SHIFT = 3,
  localparam int SET_W    = BLK_W - SET_SHIFT,
  localparam int NUM_SETS = 1 << SET_W,
  localparam int FCNT_W   = SET_W + 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                mark_en,
  input  logic [BLK_W-1:0]    mark_blk,
  input  logic                wipe,
  output logic [NUM_SETS-1:0] flags,
  output logic [FCNT_W-1:0]   fcnt,
  output logic                full
);

  logic [SET_W-1:0] mark_set;
  logic             first_hit;

  assign mark_set  = mark_blk[BLK_W-1:SET_SHIFT];
  assign first_hit = mark_en && !flags[mark_set];

  for (genvar g = 0; g < NUM_SETS; g++) begin : g_flag
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        flags[g] <= 1'b0;
      end else if (wipe) begin
        flags[g] <= 1'b0;
      end else if (mark_en && (mark_set == SET_W'(g))) begin
        flags[g] <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fcnt <= '0;
    end else if (wipe) begin
      fcnt <= '0;
    end else if (first_hit) begin
      fcnt <= fcnt + 1'b1;
    end
  end

  assign full = (fcnt == FCNT_W'(NUM_SETS));

endmodule

// File: rtl/wl_ratio_cmp.sv
module wl_ratio_cmp #(
  parameter int ECNT_W   = 16,
  parameter int THR_W    = 12,
  parameter int FCNT_W   = 8,
  localparam int PROD_W  = THR_W + FCNT_W,
  localparam int CMP_W   = (ECNT_W > PROD_W) ? ECNT_W : PROD_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              inc,
  input  logic              wipe,
  input  logic [THR_W-1:0]  thresh,
  input  logic [FCNT_W-1:0] fcnt,
  output logic              trig
);

  logic [ECNT_W-1:0] ecnt;
  logic [CMP_W-1:0]  ecnt_x;
  logic [CMP_W-1:0]  bound;

  // erase count saturates instead of wrapping
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ecnt <= '0;
    end else if (wipe) begin
      ecnt <= '0;
    end else if (inc && (ecnt != '1)) begin
      ecnt <= ecnt + 1'b1;
    end
  end

  // ratio test without a divider: ecnt >= thresh * fcnt
  assign ecnt_x = CMP_W'(ecnt);
  assign bound  = CMP_W'(thresh) * CMP_W'(fcnt);
  assign trig   = (fcnt != '0) && (ecnt_x >= bound);

endmodule

// File: rtl/wl_lfsr.sv
module wl_lfsr #(
  parameter int            MIX_W = 10,
  parameter int            OUT_W = 7,
  parameter logic [15:0]   SEED  = 16'hACE1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             mix_en,
  input  logic [MIX_W-1:0] mix_val,
  output logic [OUT_W-1:0] rnd
);
  import wl_pkg::*;

  logic [LFSR_W-1:0] state;
  logic [LFSR_W-1:0] stepped;
  logic [LFSR_W-1:0] stirred;

  assign stepped = lfsr_step(state);
  assign stirred = mix_en ? (stepped ^ LFSR_W'(mix_val)) : stepped;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= SEED;
    end else if (stirred == '0) begin
      state <= SEED;
    end else begin
      state <= stirred;
    end
  end

  assign rnd = state[OUT_W-1:0];

endmodule

// File: rtl/wl_scan_ctrl.sv
module wl_scan_ctrl #(
  parameter int  SET_W    = 7,
  localparam int NUM_SETS = 1 << SET_W
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                trig,
  input  logic                full,
  input  logic [NUM_SETS-1:0] flags,
  input  logic [SET_W-1:0]    rnd,
  output logic                clean_valid,
  input  logic                clean_ready,
  output logic [SET_W-1:0]    clean_set,
  input  logic                gc_done,
  output logic                remap_req,
  output logic [SET_W-1:0]    remap_set
);
  import wl_pkg::*;

  wl_state_e        state;
  logic [SET_W-1:0] scan_ptr;
  logic [SET_W-1:0] pick;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= WL_IDLE;
      scan_ptr  <= '0;
      pick      <= '0;
      remap_req <= 1'b0;
    end else begin
      remap_req <= 1'b0;
      if (full) begin
        scan_ptr <= rnd;
      end
      unique case (state)
        WL_IDLE: begin
          if (trig && !full) state <= WL_SCAN;
        end
        WL_SCAN: begin
          if (full) begin
            state <= WL_IDLE;
          end else begin
            scan_ptr <= scan_ptr + 1'b1;
            if (!flags[scan_ptr]) begin
              pick  <= scan_ptr;
              state <= WL_REQ;
            end
          end
        end
        WL_REQ: begin
          if (clean_ready) state <= WL_WAIT;
        end
        WL_WAIT: begin
          if (gc_done) begin
            remap_req <= 1'b1;
            state     <= WL_IDLE;
          end
        end
        default: state <= WL_IDLE;
      endcase
    end
  end

  assign clean_valid = (state == WL_REQ);
  assign clean_set   = pick;
  assign remap_set   = pick;

endmodule

// File: rtl/wear_level_trigger.sv
module wear_level_trigger #(
  parameter int          BLK_W     = 10,
  parameter int          SET_SHIFT = 3,
  parameter int          THR_W     = 12,
  parameter int          ECNT_W    = 16,
  parameter logic [15:0] SEED      = 16'hACE1,
  localparam int         SET_W     = BLK_W - SET_SHIFT,
  localparam int         NUM_SETS  = 1 << SET_W,
  localparam int         FCNT_W    = SET_W + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [THR_W-1:0] thresh,
  input  logic             erase_valid,
  output logic             erase_ready,
  input  logic [BLK_W-1:0] erase_blk,
  output logic             clean_valid,
  input  logic             clean_ready,
  output logic [SET_W-1:0] clean_set,
  input  logic             gc_done,
  output logic             remap_req,
  output logic [SET_W-1:0] remap_set
);

  logic                take;
  logic [NUM_SETS-1:0] flags;
  logic [FCNT_W-1:0]   fcnt;
  logic                full;
  logic                trig;
  logic [SET_W-1:0]    rnd;

  assign erase_ready = !full;
  assign take        = erase_valid && erase_ready;

  wl_erase_table #(
    .BLK_W(BLK_W), .SET_SHIFT(SET_SHIFT)
  ) u_table (
    .clk(clk), .rst_n(rst_n), .mark_en(take), .mark_blk(erase_blk),
    .wipe(full), .flags(flags), .fcnt(fcnt), .full(full)
  );

  wl_ratio_cmp #(
    .ECNT_W(ECNT_W), .THR_W(THR_W), .FCNT_W(FCNT_W)
  ) u_ratio (
    .clk(clk), .rst_n(rst_n), .inc(take), .wipe(full),
    .thresh(thresh), .fcnt(fcnt), .trig(trig)
  );

  wl_lfsr #(
    .MIX_W(BLK_W), .OUT_W(SET_W), .SEED(SEED)
  ) u_lfsr (
    .clk(clk), .rst_n(rst_n), .mix_en(take), .mix_val(erase_blk), .rnd(rnd)
  );

  wl_scan_ctrl #(
    .SET_W(SET_W)
  ) u_scan (
    .clk(clk), .rst_n(rst_n), .trig(trig), .full(full), .flags(flags),
    .rnd(rnd), .clean_valid(clean_valid), .clean_ready(clean_ready),
    .clean_set(clean_set), .gc_done(gc_done), .remap_req(remap_req),
    .remap_set(remap_set)
  );

endmodule

// File: rtl/wear_level_trigger_chk.sv
module wear_level_trigger_chk #(
  parameter int SET_W = 7
) (
  input logic             clk,
  input logic             rst_n,
  input logic             erase_ready,
  input logic             clean_valid,
  input logic             clean_ready,
  input logic [SET_W-1:0] clean_set,
  input logic             remap_req
);

  // R5
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clean_valid && !clean_ready) |=> (clean_valid && $stable(clean_set)));

  // R6
  one_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clean_valid && clean_ready) |=> !clean_valid);

  // R6
  remap_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    remap_req |=> !remap_req);

  // R9
  wipe_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !erase_ready |=> erase_ready);

endmodule

bind wear_level_trigger wear_level_trigger_chk #(.SET_W(SET_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .erase_ready(erase_ready),
  .clean_valid(clean_valid), .clean_ready(clean_ready),
  .clean_set(clean_set), .remap_req(remap_req)
);

// File: tb/wear_level_trigger_test.sv
module wear_level_trigger_test;

  localparam int BLK_W = 5;
  localparam int SHIFT = 2;
  localparam int THR_W = 8;
  localparam int SW    = BLK_W - SHIFT;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic [THR_W-1:0] thresh = '0;
  logic             erase_valid = 1'b0;
  logic             erase_ready;
  logic [BLK_W-1:0] erase_blk = '0;
  logic             clean_valid;
  logic             clean_ready = 1'b0;
  logic [SW-1:0]    clean_set;
  logic             gc_done = 1'b0;
  logic             remap_req;
  logic [SW-1:0]    remap_set;

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 1'b0;
  int exp_q[$];

  always #5 clk = ~clk;

  wear_level_trigger #(.BLK_W(BLK_W), .SET_SHIFT(SHIFT), .THR_W(THR_W)) uut (
    .clk(clk), .rst_n(rst_n), .thresh(thresh), .erase_valid(erase_valid),
    .erase_ready(erase_ready), .erase_blk(erase_blk), .clean_valid(clean_valid),
    .clean_ready(clean_ready), .clean_set(clean_set), .gc_done(gc_done),
    .remap_req(remap_req), .remap_set(remap_set)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  // driver: one erase notification
  task automatic erase(input int blk);
    @(negedge clk);
    erase_valid = 1'b1;
    erase_blk   = BLK_W'(blk);
    @(negedge clk);
    erase_valid = 1'b0;
  endtask

  // scoreboard push
  task automatic expect_set(input int s);
    exp_q.push_back(s);
  endtask

  task automatic quiet(input int n, input string req);
    bit seen = 1'b0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (clean_valid) seen = 1'b1;
    end
    check(!seen, req, int'(seen), 0);
  endtask

  task automatic await_req(input string req);
    bit seen = 1'b0;
    for (int i = 0; i < 40 && !seen; i++) begin
      @(negedge clk);
      if (clean_valid) seen = 1'b1;
    end
    check(seen, req, int'(seen), 1);
  endtask

  task automatic accept();
    clean_ready = 1'b1;
    @(negedge clk);
    clean_ready = 1'b0;
  endtask

  task automatic finish_gc(input int s, input string req);
    @(negedge clk);
    gc_done = 1'b1;
    @(negedge clk);
    gc_done = 1'b0;
    check(remap_req === 1'b1 && int'(remap_set) == s, req, int'(remap_set), s);
    @(negedge clk);
    check(remap_req === 1'b0, req, int'(remap_req), 0);
  endtask

  // monitor: compares every accepted request with the scoreboard
  initial begin
    forever begin
      @(negedge clk);
      #2;
      if (clean_valid && clean_ready) begin
        if (exp_q.size() == 0) begin
          check(1'b0, "R4", int'(clean_set), -1);
        end else begin
          int e;
          e = exp_q.pop_front();
          check(int'(clean_set) == e, "R4", int'(clean_set), e);
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      check(1'b0, "watchdog", 0, 1);
      summary();
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check(clean_valid === 1'b0, "R1", int'(clean_valid), 0);
    check(remap_req === 1'b0, "R1", int'(remap_req), 0);
    check(erase_ready === 1'b1, "R1", int'(erase_ready), 1);
    rst_n = 1'b1;

    // R2: empty table, thresh 0
    quiet(10, "R2");

    // R3/R8: three erases of set 0 with thresh 4 -> 3 < 4
    thresh = 8'd4;
    erase(1); erase(2); erase(3);
    quiet(6, "R3");
    // fourth erase: 4 >= 4*1; scan from 0 -> set 1
    expect_set(1);
    erase(0);
    await_req("R3");
    // R5 hold under back-pressure
    repeat (3) @(negedge clk);
    check(clean_valid === 1'b1 && clean_set == 3'd1, "R5", int'(clean_set), 1);
    accept();
    // R6: ratio still met, but request outstanding
    quiet(10, "R6");
    thresh = 8'd15;
    finish_gc(1, "R6");
    // collector erases set 1: ecnt 8, fcnt 2
    erase(4); erase(5); erase(6); erase(7);

    // R7: repeat erases keep fcnt at 2; 9 < 10, then 10 >= 10
    thresh = 8'd5;
    erase(6);
    quiet(6, "R7");
    expect_set(2);
    erase(6);
    await_req("R7");
    thresh = 8'd100;
    accept();
    finish_gc(2, "R6");
    erase(8);

    // R8/R4: mark sets 3,4,5,7 (blocks 13,17,22,31); only set 6 clear
    erase(13); erase(17); erase(22); erase(31);
    expect_set(6);
    thresh = 8'd2;           // 15 >= 14
    await_req("R8");
    thresh = 8'd100;
    accept();
    finish_gc(6, "R4");

    // R9: last clear set fills the table -> one wipe cycle
    @(negedge clk);
    erase_valid = 1'b1;
    erase_blk   = 5'd25;
    @(negedge clk);
    erase_valid = 1'b0;
    check(erase_ready === 1'b0, "R9", int'(erase_ready), 0);
    @(negedge clk);
    check(erase_ready === 1'b1, "R9", int'(erase_ready), 1);
    thresh = 8'd0;
    quiet(8, "R2");

    // R9: fresh table; mark all sets but set 4
    thresh = 8'd100;
    erase(0); erase(4); erase(8); erase(12); erase(20); erase(24); erase(28);
    thresh = 8'd3;           // 7 < 21; a stale count of 23 would fire
    quiet(8, "R9");
    expect_set(4);
    thresh = 8'd1;           // 7 >= 7, set 4 whatever the start point
    await_req("R9");
    thresh = 8'd100;
    accept();
    finish_gc(4, "R9");

    repeat (3) @(negedge clk);
    check(exp_q.size() == 0, "R4", exp_q.size(), 0);
    finished = 1'b1;
    summary();
    $finish;
  end

endmodule